// File: doc/BRIEF.md
# GPIO Input Transition Interrupt Controller

This block watches nine general-purpose ports and raises one shared active-low interrupt toward a host. The host reaches the ports through a serial register interface. Each port keeps a snapshot of the input value that the host last read. A port that is configured as an input compares the value it selects against that snapshot on every cycle. The selected value is the raw pin or a debounced copy, chosen per port. Any difference latches a per-port transition flag. A summary bit reports whether any flag is still outstanding.

The interrupt follows only ports that have their interrupt-enable bit set. It never rises while the host is in the middle of a read sequence. A qualifying change seen during a sequence is remembered and released when the STOP condition arrives. The release happens only if at least one enabled input port still has its flag set at that moment. If the host has already read the changed port before STOP, no interrupt follows. A read of the status register drops the interrupt.

Top module: `gpio_trans_irq`

## Requirements
- R1: A read strobe addressed to port register `1+i` (ports 0..8 at addresses 0x01..0x09) loads that port's selected input value into `snap_q[i]` at that clock edge.
- R2: For a port with `dir_in[i]=1` (input), a difference between the selected value and `snap_q[i]` sets `trans_flag[i]` at the next edge. This happens whatever the value of `irq_en[i]`.
- R3: The selected value is `pin_deb[i]` when `deb_sel[i]=1` and `pin_raw[i]` when `deb_sel[i]=0`. A change on the unselected source sets no flag.
- R4: A port with `dir_in[i]=0` (output) never sets its flag and never causes an interrupt.
- R5: A read of port register `1+i` clears `trans_flag[i]` at that edge, even if the input changes in the same cycle.
- R6: `trans_any` is 1 exactly while at least one `trans_flag` bit is 1. It therefore stays 1 until every flagged port has been read.
- R7: Outside a read sequence (`rd_seq=0`), `int_status` goes to 1 at the edge where an enabled input port's flag first sets.
- R8: A read strobe to address 0x26 clears `int_status` at that edge. This clear takes priority over every set.
- R9: While `rd_seq=1`, `int_status` does not rise. A qualifying change during the sequence marks a pending request. On the `stop_pulse` edge the interrupt is set if any enabled input port's flag is still set, and the pending request is discarded.
- R10: If the changed port is read before `stop_pulse`, the deferred interrupt is not asserted at STOP.
- R11: `int_n` is always the complement of `int_status`.
- R12: After reset all snapshots and flags are 0, `trans_any` is 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 9 | Instantaneous port input values |
| pin_deb | input | 9 | Debounced port input values |
| deb_sel | input | 9 | Per port: 1 selects the debounced value |
| dir_in | input | 9 | Per port: 1 = input, 0 = output |
| irq_en | input | 9 | Per port interrupt enable |
| rd_stb | input | 1 | One-cycle register read strobe |
| rd_addr | input | 8 | Address of the register being read |
| rd_seq | input | 1 | High while a host read sequence is in progress |
| stop_pulse | input | 1 | One-cycle pulse at the STOP condition |
| snap_q | output | 9 | Per-port snapshot (value last read by the host) |
| trans_flag | output | 9 | Per-port transition flags |
| trans_any | output | 1 | Summary transition status |
| int_status | output | 1 | Interrupt status bit |
| int_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions check a set of per-cycle properties on every cycle:
- a port read leaves its flag clear and its snapshot equal to the value selected at the read;
- an output port with a clear flag keeps it clear;
- the interrupt cannot rise during a read sequence except on the STOP cycle;
- a status read drops the interrupt;
- STOP always discards the pending request.

Other behaviours need the bench's scenarios, which compare against a behavioural model on every clock:
- the debounce selection;
- a summary bit that stays up until the last flagged port has been read;
- the deferred assertion at STOP;
- the cancellation that follows reading the changed port before STOP.

// File: rtl/gpio_trans_irq_pkg.sv
package gpio_trans_irq_pkg;

  // Selected comparison source for one port.
  function automatic logic pick_src(input logic raw, input logic deb, input logic use_deb);
    return use_deb ? deb : raw;
  endfunction

  // Address match of port index idx against a register address.
  function automatic logic port_hit(input logic [7:0] addr, input int unsigned base,
                                    input int unsigned idx);
    return addr == 8'(base + idx);
  endfunction

  // Source has moved away from the value the host last saw.
  function automatic logic moved(input logic src, input logic snap);
    return src != snap;
  endfunction

endpackage

// File: rtl/gpio_port_track.sv
module gpio_port_track
  import gpio_trans_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic deb,
  input  logic use_deb,
  input  logic is_in,
  input  logic rd_hit,
  output logic snap_q,
  output logic flag_q,
  output logic rise
);

  logic sel;
  logic diff;

  assign sel  = pick_src(raw, deb, use_deb);
  assign diff = is_in & moved(sel, snap_q);
  // A new transition this cycle: not yet flagged and not being read away.
  assign rise = diff & ~flag_q & ~rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (rd_hit) begin
      snap_q <= sel;
      flag_q <= 1'b0;
    end else if (diff) begin
      flag_q <= 1'b1;
    end
  end

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !flag_q);

  a_r1_snap_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> snap_q == $past(sel));

  a_r4_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_in && !flag_q) |=> !flag_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en_any,
  input  logic rd_seq,
  input  logic stop_pulse,
  input  logic clr,
  output logic irq_q,
  output logic pend_q
);

  logic set_now;
  logic set_stop;

  assign set_now  = evt & ~rd_seq;
  assign set_stop = stop_pulse & pend_q & en_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (clr) begin
      irq_q <= 1'b0;
    end else if (set_now || set_stop) begin
      irq_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (stop_pulse) begin
      pend_q <= 1'b0;
    end else if (evt && rd_seq) begin
      pend_q <= 1'b1;
    end
  end

  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);

  a_r9_no_rise_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && rd_seq && !stop_pulse) |=> !irq_q);

  a_r9_stop_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !pend_q);

  a_r10_no_stale_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && rd_seq && !en_any && !clr) |=> irq_q == $past(irq_q));

endmodule

// File: rtl/gpio_trans_irq.sv
module gpio_trans_irq
  import gpio_trans_irq_pkg::*;
#(
  parameter int unsigned NPORT     = 9,
  parameter int unsigned AW        = 8,
  parameter int unsigned PORT_BASE = 1,
  parameter int unsigned STAT_ADDR = 'h26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] pin_raw,
  input  logic [NPORT-1:0] pin_deb,
  input  logic [NPORT-1:0] deb_sel,
  input  logic [NPORT-1:0] dir_in,
  input  logic [NPORT-1:0] irq_en,
  input  logic             rd_stb,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_seq,
  input  logic             stop_pulse,
  output logic [NPORT-1:0] snap_q,
  output logic [NPORT-1:0] trans_flag,
  output logic             trans_any,
  output logic             int_status,
  output logic             int_n
);

  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  logic [NPORT-1:0] rd_hit;
  logic [NPORT-1:0] rise;
  logic             irq_evt;
  logic             en_flag_any;
  logic             stat_clr;
  logic             pend;
  logic [7:0]       addr8;

  assign addr8 = 8'(rd_addr);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign rd_hit[g] = rd_stb & port_hit(addr8, PORT_BASE, g);

    gpio_port_track u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (pin_raw[g]),
      .deb     (pin_deb[g]),
      .use_deb (deb_sel[g]),
      .is_in   (dir_in[g]),
      .rd_hit  (rd_hit[g]),
      .snap_q  (snap_q[g]),
      .flag_q  (trans_flag[g]),
      .rise    (rise[g])
    );
  end

  assign irq_evt     = |(rise & irq_en);
  assign en_flag_any = |(trans_flag & irq_en & dir_in);
  assign stat_clr    = rd_stb & (rd_addr == STAT_A);
  assign trans_any   = |trans_flag;

  gpio_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (irq_evt),
    .en_any     (en_flag_any),
    .rd_seq     (rd_seq),
    .stop_pulse (stop_pulse),
    .clr        (stat_clr),
    .irq_q      (int_status),
    .pend_q     (pend)
  );

  assign int_n = ~int_status;

  a_r7_irq_on_enabled_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && !rd_seq && !stat_clr) |=> int_status);

  a_r6_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_any && !rd_stb) |=> trans_any);

endmodule

// File: tb/gpio_trans_irq_tb.sv
module gpio_trans_irq_tb;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_raw = '0, pin_deb = '0, deb_sel = '0, dir_in = '0, irq_en = '0;
  logic rd_stb = 1'b0, rd_seq = 1'b0, stop_pulse = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [N-1:0] snap_q, trans_flag;
  logic trans_any, int_status, int_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_trans_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_deb(pin_deb),
    .deb_sel(deb_sel), .dir_in(dir_in), .irq_en(irq_en), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_seq(rd_seq), .stop_pulse(stop_pulse),
    .snap_q(snap_q), .trans_flag(trans_flag), .trans_any(trans_any),
    .int_status(int_status), .int_n(int_n)
  );

  // Behavioural reference
  bit m_snap[N];
  bit m_flag[N];
  bit m_irq, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_snap[k]) begin m_snap[k] = 0; m_flag[k] = 0; end
      m_irq = 0; m_pend = 0;
    end else begin
      bit newc, live;
      newc = 0; live = 0;
      for (int k = 0; k < N; k++) begin
        bit v, rd;
        v  = deb_sel[k] ? pin_deb[k] : pin_raw[k];
        rd = rd_stb && (int'(rd_addr) == k + 1);
        if (m_flag[k] && irq_en[k] && dir_in[k]) live = 1;
        if (rd) begin
          m_snap[k] = v; m_flag[k] = 0;
        end else if (dir_in[k] && v != m_snap[k]) begin
          if (!m_flag[k] && irq_en[k]) newc = 1;
          m_flag[k] = 1;
        end
      end
      if (rd_stb && rd_addr == 8'h26) m_irq = 0;
      else if ((newc && !rd_seq) || (stop_pulse && m_pend && live)) m_irq = 1;
      if (stop_pulse) m_pend = 0;
      else if (newc && rd_seq) m_pend = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int mvec_snap();
    int r = 0;
    for (int k = 0; k < N; k++) r |= int'(m_snap[k]) << k;
    return r;
  endfunction
  function automatic int mvec_flag();
    int r = 0;
    for (int k = 0; k < N; k++) r |= int'(m_flag[k]) << k;
    return r;
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 snapshot", int'(snap_q), mvec_snap());
    chk("R2 flags", int'(trans_flag), mvec_flag());
    chk("R6 summary", int'(trans_any), int'(mvec_flag() != 0));
    chk("R7 int_status", int'(int_status), int'(m_irq));
    chk("R11 int_n", int'(int_n), int'(!int_status));
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    rd_stb = 1; rd_addr = a; cyc(); rd_stb = 0; rd_addr = '0;
  endtask

  initial begin
    cyc(2);
    chk("R12 int_n reset", int'(int_n), 1);
    chk("R12 flags reset", int'(trans_flag), 0);
    chk("R12 summary reset", int'(trans_any), 0);
    rst_n = 1; cyc();
    dir_in = '1; irq_en = '1;
    cyc();
    // R2/R7: single change on port 2
    pin_raw[2] = 1; cyc();
    chk("R2 flag2 set", int'(trans_flag[2]), 1);
    chk("R7 irq asserted", int'(int_n), 0);
    rd(8'h26);
    chk("R8 irq cleared", int'(int_n), 1);
    chk("R6 summary held", int'(trans_any), 1);
    rd(8'h03);
    chk("R5 flag2 cleared", int'(trans_flag[2]), 0);
    chk("R1 snap2 loaded", int'(snap_q[2]), 1);
    chk("R6 summary clear", int'(trans_any), 0);
    // R6: two ports flagged
    pin_raw[0] = 1; pin_raw[8] = 1; cyc();
    rd(8'h01);
    chk("R6 still set after one read", int'(trans_any), 1);
    rd(8'h09);
    chk("R6 clear after last read", int'(trans_any), 0);
    rd(8'h26);
    // R5: read in the same cycle as a change
    pin_raw[3] = 1; rd_stb = 1; rd_addr = 8'h04; cyc(); rd_stb = 0;
    chk("R5 read wins over change", int'(trans_flag[3]), 0);
    chk("R5 snap takes new value", int'(snap_q[3]), 1);
    // R2: disabled port flags but no irq
    irq_en[4] = 0; pin_raw[4] = 1; cyc();
    chk("R2 flag4 without enable", int'(trans_flag[4]), 1);
    chk("R2 no irq when disabled", int'(int_n), 1);
    rd(8'h05); irq_en[4] = 1;
    // R3: debounce selection
    deb_sel[5] = 1; pin_raw[5] = 1; cyc(2);
    chk("R3 raw ignored under debounce", int'(trans_flag[5]), 0);
    pin_deb[5] = 1; cyc();
    chk("R3 debounced change flags", int'(trans_flag[5]), 1);
    rd(8'h06); rd(8'h26);
    // R4: output port
    dir_in[6] = 0; pin_raw[6] = 1; cyc(2);
    chk("R4 output no flag", int'(trans_flag[6]), 0);
    chk("R4 output no irq", int'(int_n), 1);
    dir_in[6] = 1; cyc(); rd(8'h07); rd(8'h26);
    // R9: deferred to STOP
    rd_seq = 1; cyc();
    pin_raw[7] = 1; cyc(3);
    chk("R9 held during sequence", int'(int_n), 1);
    chk("R9 flag set during sequence", int'(trans_flag[7]), 1);
    stop_pulse = 1; cyc(); stop_pulse = 0; rd_seq = 0;
    chk("R9 asserted at STOP", int'(int_n), 0);
    rd(8'h08); rd(8'h26);
    // R10: changed port read before STOP
    rd_seq = 1; cyc();
    pin_raw[1] = 1; cyc(2);
    rd(8'h02);
    stop_pulse = 1; cyc(); stop_pulse = 0; rd_seq = 0;
    cyc();
    chk("R10 cancelled at STOP", int'(int_n), 1);
    // Mixed pattern: several toggles outside a sequence
    for (int k = 0; k < 20; k++) begin
      pin_raw = pin_raw ^ 9'(k * 37 + 5);
      cyc();
      if (k % 3 == 0) rd(8'(1 + (k % 9)));
      if (k % 5 == 0) rd(8'h26);
    end
    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule